// File: doc/BRIEF.md
# DRAM RAS-Only Refresh Scheduler

This block keeps a multiplexed-address dynamic memory alive and brings it into service after power-on. It owns an internal row counter and a free-running interval timer. Whenever a refresh is due it raises a request towards the memory bus arbiter. When the grant comes back it drives one RAS-only refresh cycle on the shared bus. The row address goes out on the address pins, RAS is pulsed low for a fixed number of clocks and then held high for a precharge period. The column strobe is never touched, so no data moves. The address and RAS outputs are qualified by an output enable that is only high under grant, which lets the access controller share the same pins.

After reset the block stays silent for a start-up pause. It then asks for the bus once and, under that single grant, issues a fixed number of wake-up RAS cycles before it raises init-done. Only after that does periodic refresh begin. The memory's dedicated refresh-control pin is not used in this mode; the block holds it at its inactive high level. All timing is set in clock cycles through parameters. The defaults suit a 250 MHz clock: a 100 us pause, 8 wake cycles, a 15.6 us interval, 152 ns of RAS low and 120 ns of precharge.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high, and for STARTUP_CYC clocks after it is released, ref_req_o, bus_oe_o and init_done_o are 0, ras_n_o is 1 and addr_o is 0.
- R2: After the pause ref_req_o rises and stays high. Under grant exactly WAKE_CYCLES RAS pulses are issued. In the clock after the last precharge ends, init_done_o rises, ref_req_o falls and init_done_o then stays high until reset. Wake pulses do not advance the row counter, so the first periodic refresh uses row 0.
- R3: Once init_done_o is high, one refresh falls due every INTERVAL_CYC clocks, the first one INTERVAL_CYC clocks after init_done_o rises. ref_req_o stays high until every due refresh has been served.
- R4: Up to two due refreshes are held pending. Both are served back to back under one grant. A third interval that expires while two are pending is dropped.
- R5: A refresh cycle starts in the clock after an edge at which the grant is high and the block is idle with work due. ras_n_o is 0 for RAS_LOW_CYC clocks and then 1 for RAS_PRE_CYC clocks. Throughout the cycle addr_o holds the row in bits [ROW_BITS-1:0], with all upper bits 0.
- R6: The row counter resets to 0. It advances by one when a periodic refresh cycle completes, and wraps from 2**ROW_BITS-1 (127 by default) to 0.
- R7: bus_oe_o is 1 only when ref_gnt_i and ref_req_o are both 1. While bus_oe_o is 0, ras_n_o is 1 and addr_o is 0.
- R8: refresh_pin_n_o is 1 at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt_i | input | 1 | Bus grant from the arbiter, held while ref_req_o is high |
| ref_req_o | output | 1 | Bus request for wake-up or refresh cycles |
| bus_oe_o | output | 1 | Output enable for addr_o and ras_n_o on the shared bus |
| addr_o | output | ADDR_W | Multiplexed address pins, carrying the row during refresh |
| ras_n_o | output | 1 | Row strobe, active low |
| refresh_pin_n_o | output | 1 | Memory refresh-control pin, held inactive high |
| init_done_o | output | 1 | High once the power-up sequence has finished |

## Verification
The bench runs the sequence with several arbiter behaviours. An immediate grant shows the exact start cycle and the pulse widths. A grant delayed by several clocks shows that the request is held and that the cycle timing is measured from the grant rather than from the request. A grant withheld across three interval expiries separates a correct two-deep pending count from one that skips or over-counts rows, because exactly two pulses must follow in one window. A long run of more than 128 intervals with a zero-delay grant shows the row counter wrapping from 127 to 0. A behavioural model predicts request, enable, strobe, address and init-done on every clock.

// File: rtl/dref_pkg.sv
package dref_pkg;

    // Power-up phase of the scheduler
    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_WAKE  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    // State of one RAS-only cycle
    typedef enum logic [1:0] {
        CY_IDLE = 2'd0,
        CY_LOW  = 2'd1,
        CY_PRE  = 2'd2
    } cyc_e;

    // Events reported by the cycle engine each clock
    typedef struct packed {
        logic busy;     // a cycle is in progress
        logic strobe;   // RAS should be low
        logic done;     // last precharge clock of the cycle
    } cyc_evt_t;

    localparam int unsigned PEND_MAX = 2;

    // Counter width able to hold values 0..n-1 (at least one bit)
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Saturating update of the pending-refresh count
    function automatic logic [1:0] pend_update(input logic [1:0] cur,
                                               input logic       inc,
                                               input logic       dec);
        logic [2:0] sum;
        sum = {1'b0, cur} + {2'b00, inc};
        if (dec && sum != 3'd0)
            sum = sum - 3'd1;
        if (sum > 3'(PEND_MAX))
            sum = 3'(PEND_MAX);
        return sum[1:0];
    endfunction

endpackage

// File: rtl/dref_init_seq.sv
module dref_init_seq
    import dref_pkg::*;
#(
    parameter int unsigned STARTUP_CYC = 25000,
    parameter int unsigned WAKE_CYCLES = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cyc_done,
    output phase_e phase
);
    localparam int unsigned PW = cnt_w(STARTUP_CYC);
    localparam int unsigned WW = cnt_w(WAKE_CYCLES + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(STARTUP_CYC - 1);
    localparam logic [WW-1:0] WAKE_LAST  = WW'(WAKE_CYCLES - 1);

    phase_e        phase_q;
    logic [PW-1:0] pause_cnt;
    logic [WW-1:0] wake_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_PAUSE;
            pause_cnt <= '0;
            wake_cnt  <= '0;
        end else begin
            unique case (phase_q)
                PH_PAUSE: begin
                    if (pause_cnt == PAUSE_LAST)
                        phase_q <= PH_WAKE;
                    else
                        pause_cnt <= pause_cnt + 1'b1;
                end
                PH_WAKE: begin
                    if (cyc_done) begin
                        if (wake_cnt == WAKE_LAST)
                            phase_q <= PH_RUN;
                        else
                            wake_cnt <= wake_cnt + 1'b1;
                    end
                end
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/dref_interval.sv
module dref_interval
    import dref_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 3900
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       served,
    output logic [1:0] pend
);
    localparam int unsigned TW = cnt_w(INTERVAL_CYC);
    localparam logic [TW-1:0] TMR_LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] tmr;
    logic [1:0]    pend_q;
    logic          expire;

    assign expire = run && (tmr == TMR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr    <= '0;
            pend_q <= '0;
        end else if (!run) begin
            tmr    <= '0;
            pend_q <= '0;
        end else begin
            tmr    <= expire ? '0 : tmr + 1'b1;
            pend_q <= pend_update(pend_q, expire, served);
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/dref_ras_engine.sv
module dref_ras_engine
    import dref_pkg::*;
#(
    parameter int unsigned RAS_LOW_CYC = 38,
    parameter int unsigned RAS_PRE_CYC = 30,
    parameter int unsigned ROW_BITS    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                count_row,
    output cyc_evt_t            evt,
    output logic [ROW_BITS-1:0] row
);
    localparam int unsigned LONGEST = (RAS_LOW_CYC > RAS_PRE_CYC) ? RAS_LOW_CYC : RAS_PRE_CYC;
    localparam int unsigned CW = cnt_w(LONGEST);
    localparam logic [CW-1:0] LOW_LAST = CW'(RAS_LOW_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(RAS_PRE_CYC - 1);

    cyc_e                st;
    logic [CW-1:0]       cnt;
    logic [ROW_BITS-1:0] row_q;
    logic                done;

    assign done = (st == CY_PRE) && (cnt == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CY_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                CY_IDLE: begin
                    cnt <= '0;
                    if (go)
                        st <= CY_LOW;
                end
                CY_LOW: begin
                    if (cnt == LOW_LAST) begin
                        st  <= CY_PRE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CY_PRE: begin
                    if (done) begin
                        st  <= CY_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= CY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            row_q <= '0;
        else if (done && count_row)
            row_q <= row_q + 1'b1;
    end

    assign evt.busy   = (st != CY_IDLE);
    assign evt.strobe = (st == CY_LOW);
    assign evt.done   = done;
    assign row        = row_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dref_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned ROW_BITS     = 7,
    parameter int unsigned INTERVAL_CYC = 3900,
    parameter int unsigned RAS_LOW_CYC  = 38,
    parameter int unsigned RAS_PRE_CYC  = 30,
    parameter int unsigned STARTUP_CYC  = 25000,
    parameter int unsigned WAKE_CYCLES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_gnt_i,
    output logic              ref_req_o,
    output logic              bus_oe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ras_n_o,
    output logic              refresh_pin_n_o,
    output logic              init_done_o
);
    phase_e              phase;
    logic [1:0]          pend;
    cyc_evt_t            evt;
    logic [ROW_BITS-1:0] row;
    logic                want;
    logic                go;
    logic                in_run;
    logic [ADDR_W-1:0]   row_bus;

    assign in_run = (phase == PH_RUN);
    assign want   = (phase == PH_WAKE) || (in_run && pend != 2'd0);
    assign go     = ref_gnt_i && want && !evt.busy;

    dref_init_seq #(
        .STARTUP_CYC (STARTUP_CYC),
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_init (
        .clk      (clk),
        .rst      (rst),
        .cyc_done (evt.done),
        .phase    (phase)
    );

    dref_interval #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_interval (
        .clk    (clk),
        .rst    (rst),
        .run    (in_run),
        .served (evt.done),
        .pend   (pend)
    );

    dref_ras_engine #(
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .RAS_PRE_CYC (RAS_PRE_CYC),
        .ROW_BITS    (ROW_BITS)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .count_row (in_run),
        .evt       (evt),
        .row       (row)
    );

    generate
        if (ADDR_W > ROW_BITS) begin : g_pad
            assign row_bus = {{(ADDR_W - ROW_BITS){1'b0}}, row};
        end else begin : g_exact
            assign row_bus = row[ADDR_W-1:0];
        end
    endgenerate

    assign ref_req_o       = want || evt.busy;
    assign bus_oe_o        = ref_gnt_i && ref_req_o;
    assign ras_n_o         = !(bus_oe_o && evt.strobe);
    assign addr_o          = bus_oe_o ? row_bus : '0;
    assign refresh_pin_n_o = 1'b1;
    assign init_done_o     = in_run;

endmodule

// File: rtl/dref_chk.sv
module dref_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_gnt_i,
    input logic              ref_req_o,
    input logic              bus_oe_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              ras_n_o,
    input logic              init_done_o
);
    // R7
    oe_under_grant_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe_o |-> (ref_gnt_i && ref_req_o));

    // R7
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_o |-> (ras_n_o && addr_o == '0));

    // R5
    row_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n_o && $past(!ras_n_o)) |-> $stable(addr_o));

    // R2
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done_o |=> init_done_o);

    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_req_o && !ref_gnt_i) |=> ref_req_o);

    // R1
    silent_before_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_done_o && !ref_req_o) |-> (ras_n_o && !bus_oe_o));
endmodule

bind dram_refresh_sched dref_chk #(.ADDR_W(ADDR_W)) u_dref_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_gnt_i   (ref_gnt_i),
    .ref_req_o   (ref_req_o),
    .bus_oe_o    (bus_oe_o),
    .addr_o      (addr_o),
    .ras_n_o     (ras_n_o),
    .init_done_o (init_done_o)
);

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
    localparam int ADDR_W   = 8;
    localparam int ROW_BITS = 7;
    localparam int INTERVAL = 200;
    localparam int RLOW     = 5;
    localparam int RPRE     = 4;
    localparam int STARTUP  = 100;
    localparam int WAKE     = 8;
    localparam int NROWS    = 1 << ROW_BITS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b0;
    logic req, oe, ras_n, rpin_n, idone;
    logic [ADDR_W-1:0] addr;

    always #2 clk = ~clk;

    dram_refresh_sched #(
        .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .INTERVAL_CYC(INTERVAL),
        .RAS_LOW_CYC(RLOW), .RAS_PRE_CYC(RPRE), .STARTUP_CYC(STARTUP),
        .WAKE_CYCLES(WAKE)
    ) dut_i (
        .clk(clk), .rst(rst), .ref_gnt_i(gnt), .ref_req_o(req),
        .bus_oe_o(oe), .addr_o(addr), .ras_n_o(ras_n),
        .refresh_pin_n_o(rpin_n), .init_done_o(idone)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_ph, m_pause, m_wake, m_tmr, m_pend, m_st, m_cnt, m_row;
    int m_dropped;

    always @(posedge clk) begin
        bit done, start, expire, want;
        int p;
        if (rst) begin
            m_ph = 0; m_pause = 0; m_wake = 0; m_tmr = 0; m_pend = 0;
            m_st = 0; m_cnt = 0; m_row = 0; m_dropped = 0;
        end else begin
            done   = (m_st == 2) && (m_cnt == RPRE - 1);
            want   = (m_ph == 1) || (m_ph == 2 && m_pend > 0);
            start  = gnt && (m_st == 0) && want;
            expire = (m_ph == 2) && (m_tmr == INTERVAL - 1);
            if (m_ph == 2) begin
                p = m_pend + (expire ? 1 : 0) - (done ? 1 : 0);
                if (p > 2) begin p = 2; m_dropped++; end
                m_pend = p;
                m_tmr = expire ? 0 : m_tmr + 1;
                if (done) m_row = (m_row + 1) % NROWS;
            end
            if (m_ph == 0) begin
                if (m_pause == STARTUP - 1) m_ph = 1; else m_pause++;
            end else if (m_ph == 1 && done) begin
                m_wake++;
                if (m_wake == WAKE) m_ph = 2;
            end
            case (m_st)
                0: begin m_cnt = 0; if (start) m_st = 1; end
                1: if (m_cnt == RLOW - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
                default: if (m_cnt == RPRE - 1) begin m_st = 0; m_cnt = 0; end else m_cnt++;
            endcase
        end
    end

    // ---------------- arbiter and per-clock comparison ----------------
    int  gnt_delay = 1;
    bit  gnt_block = 0;
    int  wait_cnt  = 0;
    bit  compare_on = 0;
    int  win_pulses = 0, last_win = 0;
    int  pulses_pre_done = 0;
    int  last_row = -1;
    bit  wrap_seen = 0;
    int  seq_err = 0;
    logic ras_prev = 1'b1;

    always @(negedge clk) begin
        bit e_req, e_oe, e_ras_n;
        int e_addr;
        if (compare_on) begin
            e_req   = (m_ph == 1) || (m_ph == 2 && (m_pend > 0 || m_st != 0));
            e_oe    = gnt && e_req;
            e_ras_n = !(e_oe && m_st == 1);
            e_addr  = e_oe ? m_row : 0;
            check("R3 ref_req_o", req, e_req);
            check("R7 bus_oe_o", oe, e_oe);
            check("R5 ras_n_o", ras_n, e_ras_n);
            check("R5 R6 addr_o", addr, e_addr);
            check("R2 init_done_o", idone, m_ph == 2);
            check("R8 refresh_pin_n_o", rpin_n, 1);
        end
        // pulse bookkeeping on falling RAS
        if (ras_prev && !ras_n) begin
            win_pulses++;
            if (!idone) pulses_pre_done++;
            else begin
                if (last_row >= 0 && int'(addr) != (last_row + 1) % NROWS) seq_err++;
                if (last_row == NROWS - 1 && addr == 0) wrap_seen = 1;
                last_row = addr;
            end
        end
        ras_prev = ras_n;
        // arbiter
        if (!req) begin
            if (gnt) last_win = win_pulses;
            gnt = 0; wait_cnt = 0; win_pulses = 0;
        end else if (!gnt && !gnt_block) begin
            if (wait_cnt >= gnt_delay) gnt = 1; else wait_cnt++;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        wait_clks(4);
        @(negedge clk);
        // R1: reset state
        check("R1 reset req", req, 0);
        check("R1 reset oe", oe, 0);
        check("R1 reset ras_n", ras_n, 1);
        check("R1 reset addr", addr, 0);
        check("R1 reset init_done", idone, 0);
        check("R8 reset refresh pin", rpin_n, 1);
        rst = 0;
        compare_on = 1;
        // R1: silent through the pause
        wait_clks(STARTUP - 2);
        @(negedge clk);
        check("R1 pause end req", req, 0);
        wait_clks(2);
        @(negedge clk);
        check("R2 wake req", req, 1);
        while (!idone) @(negedge clk);
        check("R2 wake pulse count", pulses_pre_done, WAKE);
        check("R2 req low at done", req, 0);

        // R3: immediate-ish grant
        gnt_delay = 1;
        wait_clks(INTERVAL * 10);
        // R3: delayed grant
        gnt_delay = 3;
        wait_clks(INTERVAL * 10);

        // R4: withhold grant over three expiries
        gnt_delay = 0;
        @(negedge clk);
        while (req) @(negedge clk);
        gnt_block = 1;
        while (!req) @(negedge clk);
        wait_clks(INTERVAL * 2 + INTERVAL / 2);
        @(negedge clk);
        check("R4 pending saturated drops", m_dropped > 0, 1);
        gnt_block = 0;
        while (req) @(negedge clk);
        @(negedge clk);
        check("R4 back-to-back pulses in window", last_win, 2);

        // R6: run past a full wrap
        wait_clks(INTERVAL * (NROWS + 4));
        check("R6 row wrap seen", wrap_seen, 1);
        check("R6 row sequence errors", seq_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule